// File: doc/BRIEF.md
# Run-Skipping Sequential Fraction Divider

This block divides a double-width positive binary fraction by a single-width positive binary fraction. The dividend is taken as an integer of 2·WIDTH bits and the divisor as an integer of WIDTH bits. The block returns a WIDTH-bit quotient and a WIDTH-bit remainder. Seen as fractions, the quotient is the dividend over the divisor with WIDTH fraction bits, and the remainder is what is left over.

A single start cycle loads the operands. In that cycle the divisor is scaled up until its top bit is set, and the dividend is shifted left by the same amount. The partial remainder is kept in a signed, non-restoring form. In each working cycle the block looks at that partial remainder:
- If it begins with a run of bits equal to its sign, the whole run is passed over in one shift. The matching quotient bits go in: 0s when the partial remainder is positive, 1s when it is negative.
- Otherwise the normalized divisor is subtracted (positive partial remainder) or added (negative partial remainder), and one quotient bit is produced.

The operation ends once WIDTH quotient positions have been filled. A final cycle adds the divisor back to a negative remainder and undoes the normalization scaling.

Operands whose upper dividend half is not below the divisor, and a zero divisor, are reported as overflow without running the loop.

Top module: `runskip_frac_div`

## Requirements
- R1: When no overflow is flagged, `quotient` equals floor(`dividend` / `divisor`) taken as unsigned integers.
- R2: When no overflow is flagged, `remainder` equals `dividend` mod `divisor`, so it is always below the divisor.
- R3: Overflow is flagged when `divisor` is zero or when `dividend[2W-1:W]` is greater than or equal to `divisor`. In that case `done` and `ovf` are both high in the cycle after the edge that sampled `start`, and `quotient` and `remainder` read 0.
- R4: `done` is high for one cycle per operation. The result outputs keep their value until the next operation completes.
- R5: Count the edge that samples `start` as edge 0. For any operands, `done` is high no later than the cycle following edge WIDTH+1.
- R6: A zero dividend with a nonzero divisor is covered by two run-skipping shifts. `done` is then high exactly in the cycle following edge 3.
- R7: A `start` pulse that arrives while an operation is in progress is ignored. The result is that of the operation already running.
- R8: After reset, `done`, `ovf`, `quotient` and `remainder` are all 0.
- R9: Divisors with leading zeros, down to a divisor of 1, are normalized internally and still give the quotient and remainder stated in R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Loads the operands and begins a division when the block is idle |
| divisor | input | WIDTH | Divisor fraction |
| dividend | input | 2*WIDTH | Dividend fraction, upper half must be below the divisor |
| done | output | 1 | One-cycle completion pulse |
| ovf | output | 1 | Divide overflow, valid while `done` is high |
| quotient | output | WIDTH | Quotient fraction |
| remainder | output | WIDTH | Remainder, scaled back to the caller's divisor |

## Verification
The operand set is chosen so that each path through the datapath is exercised:
- Divisors that are already normalized (top bit set) run with a zero normalization shift.
- Divisors with up to seven leading zeros check the scaling on the way in and the rescaling of the remainder on the way out.
- Dividends made of long runs of 0s or long runs of 1s drive the multi-bit skip, including runs cut short by the remaining position count.
- Mixed bit patterns force alternating subtract and add steps, which separates a wrong skip length or a wrong inserted bit from a wrong add/subtract step.

Operands that sit exactly at the overflow limit, and a zero divisor, check that the overflow test is inclusive. A zero dividend pins the exact skip latency, and a second start issued while busy shows that the operands are not reloaded.

// File: rtl/runskip_div_pkg.sv
package runskip_div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_e;
endpackage

// File: rtl/runskip_div_norm.sv
// Scales the divisor until its top bit is set and shifts the dividend by the
// same amount. A zero divisor reports a shift of WIDTH; that case is handled
// as an overflow by the caller.
module runskip_div_norm #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CW = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0]   den_i,
  input  logic [2*WIDTH-1:0] num_i,
  output logic [WIDTH-1:0]   den_o,
  output logic [2*WIDTH-1:0] num_o,
  output logic [CW-1:0]      sh_o
);
  int   lz;
  logic seen;

  always_comb begin
    lz   = 0;
    seen = 1'b0;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (!seen) begin
        if (den_i[i]) seen = 1'b1;
        else          lz   = lz + 1;
      end
    end
    sh_o  = CW'(lz);
    den_o = den_i << lz;
    num_o = num_i << lz;
  end
endmodule

// File: rtl/runskip_div_step.sv
// One working cycle. If the partial remainder starts with a run of sign-equal
// bits, the whole run is shifted over and the quotient bit that matches the
// sign is filled in. Otherwise one non-restoring add or subtract is done.
module runskip_div_step #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned CW = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH:0]   part_i,   // signed partial remainder
  input  logic [WIDTH-1:0] qr_i,     // dividend bits still to consume / quotient bits
  input  logic [WIDTH-1:0] den_i,    // normalized divisor
  input  logic [CW-1:0]    left_i,   // positions still to fill
  output logic [WIDTH:0]   part_o,
  output logic [WIDTH-1:0] qr_o,
  output logic [CW-1:0]    used_o
);
  localparam int unsigned CATW = 2 * WIDTH + 1;

  int              run_len;
  int              sh;
  logic            in_run;
  logic            sgn;
  logic [CATW-1:0] cat;
  logic [CATW-1:0] fill;
  logic [WIDTH:0]  twice;
  logic [WIDTH:0]  arith;

  always_comb begin
    sgn     = part_i[WIDTH];
    run_len = 0;
    in_run  = 1'b1;
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (in_run) begin
        if (part_i[i] == sgn) run_len = run_len + 1;
        else                  in_run  = 1'b0;
      end
    end

    // 2P + next dividend bit, modulo 2^(WIDTH+1); the add/sub result fits.
    twice = {part_i[WIDTH-1:0], qr_i[WIDTH-1]};
    arith = sgn ? (twice + {1'b0, den_i}) : (twice - {1'b0, den_i});

    sh = (run_len - 1 < int'(left_i)) ? (run_len - 1) : int'(left_i);
    if (sh < 0) sh = 0;
    fill = sgn ? ~({CATW{1'b1}} << sh) : '0;
    cat  = ({part_i, qr_i} << sh) | fill;

    if (run_len >= 2) begin
      part_o = cat[CATW-1:WIDTH];
      qr_o   = cat[WIDTH-1:0];
      used_o = CW'(sh);
    end else begin
      part_o = arith;
      qr_o   = {qr_i[WIDTH-2:0], ~arith[WIDTH]};
      used_o = CW'(1);
    end
  end
endmodule

// File: rtl/runskip_frac_div.sv
module runskip_frac_div #(
  parameter int unsigned WIDTH = 8   // at least 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   divisor,
  input  logic [2*WIDTH-1:0] dividend,
  output logic               done,
  output logic               ovf,
  output logic [WIDTH-1:0]   quotient,
  output logic [WIDTH-1:0]   remainder
);
  import runskip_div_pkg::*;

  localparam int unsigned CW = $clog2(WIDTH + 1);

  // reset: asserted at once, released on a clock edge
  logic [1:0] rst_sync;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  div_state_e       st_q, st_d;
  logic [WIDTH:0]   part_q, part_d;
  logic [WIDTH-1:0] qr_q, qr_d;
  logic [WIDTH-1:0] den_q, den_d;
  logic [CW-1:0]    shamt_q, shamt_d;
  logic [CW-1:0]    left_q, left_d;
  logic             done_d, ovf_d;
  logic [WIDTH-1:0] quot_d, rem_d;
  logic             work_en, res_en;

  logic [WIDTH-1:0]   den_n;
  logic [2*WIDTH-1:0] num_n;
  logic [CW-1:0]      sh_n;
  logic [WIDTH:0]     part_s;
  logic [WIDTH-1:0]   qr_s;
  logic [CW-1:0]      used_s;
  logic               ovf_cond;
  logic [WIDTH-1:0]   fixed_rem;

  runskip_div_norm #(.WIDTH(WIDTH)) u_norm (
    .den_i(divisor), .num_i(dividend),
    .den_o(den_n), .num_o(num_n), .sh_o(sh_n)
  );

  runskip_div_step #(.WIDTH(WIDTH)) u_step (
    .part_i(part_q), .qr_i(qr_q), .den_i(den_q), .left_i(left_q),
    .part_o(part_s), .qr_o(qr_s), .used_o(used_s)
  );

  assign ovf_cond  = (divisor == '0) || (dividend[2*WIDTH-1:WIDTH] >= divisor);
  assign fixed_rem = part_q[WIDTH-1:0] + (part_q[WIDTH] ? den_q : '0);

  always_comb begin
    st_d    = st_q;
    part_d  = part_q;
    qr_d    = qr_q;
    den_d   = den_q;
    shamt_d = shamt_q;
    left_d  = left_q;
    work_en = 1'b0;
    res_en  = 1'b0;
    done_d  = 1'b0;
    ovf_d   = ovf;
    quot_d  = quotient;
    rem_d   = remainder;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          work_en = 1'b1;
          if (ovf_cond) begin
            res_en = 1'b1;
            done_d = 1'b1;
            ovf_d  = 1'b1;
            quot_d = '0;
            rem_d  = '0;
          end else begin
            part_d  = {1'b0, num_n[2*WIDTH-1:WIDTH]};
            qr_d    = num_n[WIDTH-1:0];
            den_d   = den_n;
            shamt_d = sh_n;
            left_d  = CW'(WIDTH);
            st_d    = ST_RUN;
          end
        end
      end
      ST_RUN: begin
        work_en = 1'b1;
        part_d  = part_s;
        qr_d    = qr_s;
        left_d  = left_q - used_s;
        if (left_q == used_s) st_d = ST_FIX;
      end
      default: begin
        res_en = 1'b1;
        done_d = 1'b1;
        ovf_d  = 1'b0;
        quot_d = qr_q;
        rem_d  = fixed_rem >> shamt_q;
        st_d   = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q      <= ST_IDLE;
      part_q    <= '0;
      qr_q      <= '0;
      den_q     <= '0;
      shamt_q   <= '0;
      left_q    <= '0;
      done      <= 1'b0;
      ovf       <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      st_q <= st_d;
      done <= done_d;
      if (work_en) begin
        part_q  <= part_d;
        qr_q    <= qr_d;
        den_q   <= den_d;
        shamt_q <= shamt_d;
        left_q  <= left_d;
      end
      if (res_en) begin
        ovf       <= ovf_d;
        quotient  <= quot_d;
        remainder <= rem_d;
      end
    end
  end

  logic signed [WIDTH+1:0] p_sx, d_sx;
  assign p_sx = {part_q[WIDTH], part_q};
  assign d_sx = {2'b00, den_q};

  // R9
  norm_msb_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_RUN) |-> den_q[WIDTH-1]);
  // R1
  part_bound_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_RUN) |-> ((p_sx < d_sx) && (p_sx >= -d_sx)));
  // R2
  rem_below_div_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (done && !ovf) |-> ((WIDTH + 1)'(remainder) << shamt_q) < (WIDTH + 1)'(den_q));
  // R3
  ovf_with_done_chk: assert property (@(posedge clk) disable iff (!rst_s)
    ovf && !$stable(ovf) |-> done);
  // R4
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $rose(done) |-> ($past(st_q) == ST_FIX) || $past(start));
  // R5
  left_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (st_q == ST_RUN) |=> (left_q < $past(left_q)));
endmodule

// File: tb/runskip_frac_div_test.sv
`timescale 1ns/1ps
module runskip_frac_div_test;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           start;
  logic [W-1:0]   divisor;
  logic [2*W-1:0] dividend;
  logic           done, ovf;
  logic [W-1:0]   quotient, remainder;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  runskip_frac_div #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .divisor(divisor),
    .dividend(dividend), .done(done), .ovf(ovf),
    .quotient(quotient), .remainder(remainder)
  );

  // {divisor, dividend}
  localparam logic [23:0] VEC [0:11] = '{
    24'h05_0017, 24'hFF_FEFF, 24'h01_00AB, 24'h80_7FFF,
    24'h03_0255, 24'h0A_0037, 24'hC3_5A5A, 24'h07_0700,
    24'h00_0000, 24'h40_3FC0, 24'h11_10FF, 24'h9D_9C00
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drives one operation, returns the negedge index at which done was seen
  task automatic run_op(input logic [W-1:0] b, input logic [2*W-1:0] a, output int lat);
    @(negedge clk);
    divisor  = b;
    dividend = a;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat   = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    int eq, er;
    bit eo;
    rst_n    = 1'b0;
    start    = 1'b0;
    divisor  = '0;
    dividend = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R8 reset state
    check(done == 1'b0, "R8 done", int'(done), 0);
    check(ovf == 1'b0, "R8 ovf", int'(ovf), 0);
    check(quotient == '0, "R8 quotient", int'(quotient), 0);
    check(remainder == '0, "R8 remainder", int'(remainder), 0);

    // table walk: R1 R2 R3 R5 R9
    for (int i = 0; i < 12; i++) begin
      logic [W-1:0]   b;
      logic [2*W-1:0] a;
      b  = VEC[i][23:16];
      a  = VEC[i][15:0];
      eo = (b == 0) || (a[2*W-1:W] >= b);
      eq = eo ? 0 : int'(a) / int'(b);
      er = eo ? 0 : int'(a) % int'(b);
      run_op(b, a, lat);
      check(done == 1'b1, "R5 done seen", int'(done), 1);
      check(ovf == eo, "R3 ovf flag", int'(ovf), int'(eo));
      check(int'(quotient) == eq, "R1 R9 quotient", int'(quotient), eq);
      check(int'(remainder) == er, "R2 R9 remainder", int'(remainder), er);
      if (eo) check(lat == 1, "R3 ovf latency", lat, 1);
      else    check(lat <= W + 2, "R5 latency bound", lat, W + 2);
      @(negedge clk);
      check(done == 1'b0, "R4 single pulse", int'(done), 0);
    end

    // R6 zero dividend: two skips
    run_op(8'h37, 16'h0000, lat);
    check(lat == 4, "R6 zero dividend latency", lat, 4);
    check(quotient == '0, "R6 quotient", int'(quotient), 0);
    check(remainder == '0, "R6 remainder", int'(remainder), 0);

    // R7 start while busy is ignored
    @(negedge clk);
    divisor  = 8'h0B;
    dividend = 16'h0A55;
    start    = 1'b1;
    @(negedge clk);
    divisor  = 8'h01;
    dividend = 16'h0000;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat   = 2;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    check(int'(quotient) == 16'h0A55 / 8'h0B, "R7 quotient of first op", int'(quotient), 16'h0A55 / 8'h0B);
    check(int'(remainder) == 16'h0A55 % 8'h0B, "R7 remainder of first op", int'(remainder), 16'h0A55 % 8'h0B);

    // R4 outputs hold after the pulse
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R4 done low", int'(done), 0);
    check(int'(quotient) == 16'h0A55 / 8'h0B, "R4 quotient holds", int'(quotient), 16'h0A55 / 8'h0B);

    // R3 boundary: upper half one below divisor is legal, equal is overflow
    run_op(8'h01, 16'h00FF, lat);
    check(ovf == 1'b0, "R3 below limit", int'(ovf), 0);
    check(quotient == 8'hFF, "R9 divisor one", int'(quotient), 8'hFF);
    run_op(8'hFF, 16'hFF00, lat);
    check(ovf == 1'b1, "R3 at limit", int'(ovf), 1);
    check(quotient == '0 && remainder == '0, "R3 zeroed outputs", int'({quotient, remainder}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule